// File: doc/BRIEF.md
# Bus Hold Arbiter

This block lets a controller share its external bus with other bus masters through a three-wire handshake: a hold request, a hold acknowledge and a bus request. Configuration inputs enable it and choose its role. When arbitration is disabled, the block leaves every pin undriven and never stalls the local bus sequencer.

In master mode the controller owns the bus. It gives the bus up when another device raises the hold request, and only once the current local bus cycle has ended. It then drives the acknowledge pin high. While it has given the bus away, it raises its own bus request whenever a local access is waiting. In slave mode the acknowledge pin becomes an input. The unit raises its bus request to ask for the bus and may drive the bus only while the acknowledge input is active. Two units can therefore be wired pin to pin: each unit's request goes to the other's hold input, and the master's acknowledge goes to the slave's acknowledge.

The local sequencer reports whether a bus cycle is in progress and whether an access is pending. In return it receives a bus-released flag, which tells it to float the bus, and a stall flag, which blocks new local cycles. Both asynchronous pin inputs, hold and acknowledge, pass through a synchronizer before any logic uses them.

Top module: `hold_arbiter`

## Requirements
- R1: With `arb_en` low, `hlda_oe`, `breq_o`, `bus_released_o` and `loc_stall_o` are all 0, whatever the other inputs do.
- R2: With `arb_en` high, `hlda_oe` is 1 when `slave_mode` is 0 (acknowledge pin is an output) and 0 when `slave_mode` is 1 (acknowledge pin is an input).
- R3: `hold_i` and `hlda_i` take effect only after SYNC_STAGES rising edges. In master mode with the bus idle, `hlda_o` goes high SYNC_STAGES+1 edges after `hold_i` rises.
- R4: In master mode, `hlda_o` never rises at an edge where `cyc_busy_i` is high. The grant waits for the current cycle to finish.
- R5: In master mode, while `hlda_o` is 1, both `bus_released_o` and `loc_stall_o` are 1.
- R6: In master mode, `breq_o` equals `hlda_o` AND `loc_pending_i`.
- R7: In master mode, `hlda_o` falls at the first edge after the synchronized hold request goes low, so `bus_released_o` drops at that same edge.
- R8: In master mode, `loc_stall_o` is 1 as soon as the synchronized hold request is high, even while the grant is still waiting on a busy cycle.
- R9: In slave mode, `bus_released_o` and `loc_stall_o` are 1 exactly while the synchronized `hlda_i` is 0.
- R10: In slave mode, `breq_o` is a register. After an edge it is 1 if, at that edge, either a local access was pending with the synchronized hold low, or a cycle was busy while the synchronized acknowledge was high.
- R11: In slave mode, while the synchronized `hold_i` is high, a pending access alone does not keep `breq_o` asserted. The slave yields after its current cycle.
- R12: In slave mode, or when arbitration is disabled, the master grant state is cleared, so `hlda_o` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | Arbitration enable configuration bit |
| slave_mode | input | 1 | 0 = master role, 1 = slave role |
| hold_i | input | 1 | Hold request pin, asynchronous |
| hlda_i | input | 1 | Acknowledge pin as input (slave mode), asynchronous |
| cyc_busy_i | input | 1 | Local bus cycle in progress |
| loc_pending_i | input | 1 | Local access waiting for the bus |
| hlda_o | output | 1 | Acknowledge pin value (master mode) |
| hlda_oe | output | 1 | Output enable of the acknowledge pin |
| breq_o | output | 1 | Bus request pin |
| bus_released_o | output | 1 | Local side must float the bus |
| loc_stall_o | output | 1 | Local sequencer must not start a new cycle |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. The grant and release latencies are therefore short enough to pin down edge by edge, and every pipeline position of the synchronizer is visited when HOLD and the acknowledge input toggle on consecutive cycles. A long pseudo-random phase follows. It switches role and enable on the fly, which reaches the mode-change paths: a grant dropped by a switch to slave mode, and a slave request cut off by a disable.

// File: rtl/hold_arbiter.sv
module hold_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_en,
  input  logic slave_mode,
  input  logic hold_i,
  input  logic hlda_i,
  input  logic cyc_busy_i,
  input  logic loc_pending_i,
  output logic hlda_o,
  output logic hlda_oe,
  output logic breq_o,
  output logic bus_released_o,
  output logic loc_stall_o
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] hold_sr, ack_sr;
  logic         held, sreq;

  wire hold_s    = hold_sr[MSB];
  wire ack_s     = ack_sr[MSB];
  wire master_on = arb_en & ~slave_mode;
  wire slave_on  = arb_en & slave_mode;

  wire held_d = master_on & hold_s & (held | ~cyc_busy_i);
  wire sreq_d = slave_on & ((cyc_busy_i & ack_s) | (loc_pending_i & ~hold_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_sr <= '0;
      ack_sr  <= '0;
      held    <= 1'b0;
      sreq    <= 1'b0;
    end else begin
      hold_sr <= {hold_sr[MSB-1:0], hold_i};
      ack_sr  <= {ack_sr[MSB-1:0], hlda_i};
      held    <= held_d;
      sreq    <= sreq_d;
    end
  end

  assign hlda_o         = held;
  assign hlda_oe        = master_on;
  assign breq_o         = slave_on ? sreq : (master_on & held & loc_pending_i);
  assign bus_released_o = slave_on ? ~ack_s : (master_on & held);
  assign loc_stall_o    = slave_on ? ~ack_s : (master_on & (held | hold_s));

endmodule

// File: rtl/hold_arbiter_chk.sv
module hold_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic arb_en,
  input logic slave_mode,
  input logic hold_i,
  input logic hlda_i,
  input logic cyc_busy_i,
  input logic loc_pending_i,
  input logic hlda_o,
  input logic hlda_oe,
  input logic breq_o,
  input logic bus_released_o,
  input logic loc_stall_o
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |-> !(hlda_oe || breq_o || bus_released_o || loc_stall_o)); // R1

  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_o) |-> $past(!cyc_busy_i)); // R4

  AST_HELD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && !slave_mode && hlda_o) |-> (bus_released_o && loc_stall_o)); // R5

  AST_MREQ_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && !slave_mode && !hlda_o) |-> !breq_o); // R6

  AST_SREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && slave_mode && $rose(breq_o)) |-> $past(loc_pending_i || cyc_busy_i)); // R10

  AST_SLAVE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode || !arb_en) |=> !hlda_o); // R12

endmodule

bind hold_arbiter hold_arbiter_chk u_chk (.*);

// File: tb/sim_hold_arbiter.sv
`timescale 1ns/1ps
module sim_hold_arbiter;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_en = 0, slave_mode = 0, hold_i = 0, hlda_i = 0, cyc_busy_i = 0, loc_pending_i = 0;
  logic hlda_o, hlda_oe, breq_o, bus_released_o, loc_stall_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hold_arbiter #(.SYNC_STAGES(SYNC)) u0 (.*);

  bit hq[SYNC];
  bit aq[SYNC];
  bit m_held, m_sreq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) begin hq[i] = 0; aq[i] = 0; end
      m_held = 0; m_sreq = 0;
    end else begin
      bit hs, as;
      hs = hq[SYNC-1]; as = aq[SYNC-1];
      if (arb_en && !slave_mode) begin
        if (m_held) m_held = hs;
        else m_held = hs && !cyc_busy_i;
      end else m_held = 0;
      if (arb_en && slave_mode)
        m_sreq = (cyc_busy_i && as) || (loc_pending_i && !hs);
      else m_sreq = 0;
      for (int i = SYNC-1; i > 0; i--) begin hq[i] = hq[i-1]; aq[i] = aq[i-1]; end
      hq[0] = hold_i; aq[0] = hlda_i;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit e_oe, e_breq, e_rel, e_stall;
    bit hs, as;
    hs = hq[SYNC-1]; as = aq[SYNC-1];
    e_oe = arb_en && !slave_mode;
    if (!arb_en) begin
      e_breq = 0; e_rel = 0; e_stall = 0;
    end else if (slave_mode) begin
      e_breq = m_sreq; e_rel = !as; e_stall = !as;
    end else begin
      e_breq = m_held && loc_pending_i; e_rel = m_held; e_stall = m_held || hs;
    end
    chk(arb_en ? "R2" : "R1", "hlda_oe", hlda_oe, e_oe);
    chk(slave_mode ? "R12" : "R4", "hlda_o", hlda_o, m_held);
    chk(!arb_en ? "R1" : (slave_mode ? "R10" : "R6"), "breq_o", breq_o, e_breq);
    chk(!arb_en ? "R1" : (slave_mode ? "R9" : "R5"), "bus_released_o", bus_released_o, e_rel);
    chk(!arb_en ? "R1" : (slave_mode ? "R9" : "R8"), "loc_stall_o", loc_stall_o, e_stall);
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_n) compare_all();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1: reset state and disabled block ignores pins
    chk("R1", "reset hlda_o", hlda_o, 0);
    chk("R1", "reset breq_o", breq_o, 0);
    hold_i = 1; hlda_i = 1; loc_pending_i = 1; cyc_busy_i = 1;
    tick(4);
    chk("R1", "disabled breq_o", breq_o, 0);
    chk("R1", "disabled stall", loc_stall_o, 0);
    hold_i = 0; hlda_i = 0; loc_pending_i = 0; cyc_busy_i = 0;
    tick(3);

    arb_en = 1;
    tick(1);
    chk("R2", "master drives ack pin", hlda_oe, 1);

    // R4/R8: grant waits for busy cycle, stall rises early
    cyc_busy_i = 1; hold_i = 1;
    tick(2);
    chk("R8", "stall on synced hold", loc_stall_o, 1);
    chk("R4", "no grant while busy", hlda_o, 0);
    tick(3);
    chk("R4", "still no grant while busy", hlda_o, 0);
    cyc_busy_i = 0;
    tick(1);
    chk("R4", "grant after idle", hlda_o, 1);
    chk("R5", "bus floated when held", bus_released_o, 1);

    loc_pending_i = 1;
    tick(1);
    chk("R6", "breq while held and pending", breq_o, 1);
    loc_pending_i = 0;
    tick(1);
    chk("R6", "breq off without pending", breq_o, 0);

    // R7: release timing
    hold_i = 0;
    tick(2);
    chk("R7", "ack held until edge after sync", hlda_o, 1);
    tick(1);
    chk("R7", "ack released", hlda_o, 0);
    chk("R7", "bus reclaimed", bus_released_o, 0);

    // R3: synchronizer latency
    hold_i = 1;
    tick(1);
    chk("R3", "hold not yet seen", loc_stall_o, 0);
    tick(1);
    chk("R3", "hold seen, no grant yet", hlda_o, 0);
    tick(1);
    chk("R3", "grant at SYNC+1 edges", hlda_o, 1);

    // R12: switch role while holding
    slave_mode = 1; hold_i = 0;
    tick(1);
    chk("R12", "grant cleared in slave", hlda_o, 0);
    chk("R2", "ack pin input in slave", hlda_oe, 0);
    tick(3);

    // Slave requests
    loc_pending_i = 1;
    tick(1);
    chk("R10", "slave request after pending", breq_o, 1);
    chk("R9", "slave floats without ack", bus_released_o, 1);
    hlda_i = 1;
    tick(1);
    chk("R9", "ack not yet synced", loc_stall_o, 1);
    tick(1);
    chk("R9", "slave drives with ack", bus_released_o, 0);
    chk("R9", "slave no stall with ack", loc_stall_o, 0);
    cyc_busy_i = 1; loc_pending_i = 0; hold_i = 1;
    tick(3);
    chk("R10", "busy cycle keeps request", breq_o, 1);
    cyc_busy_i = 0; loc_pending_i = 1;
    tick(1);
    chk("R11", "slave yields under hold", breq_o, 0);
    hlda_i = 0; hold_i = 0;
    tick(3);
    chk("R10", "slave re-requests", breq_o, 1);
    chk("R9", "released after ack drop", bus_released_o, 1);

    // Random phase, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 31) == 0) arb_en = ~arb_en;
      if ($urandom_range(0, 47) == 0) slave_mode = ~slave_mode;
      if ($urandom_range(0, 5) == 0) hold_i = ~hold_i;
      if ($urandom_range(0, 5) == 0) hlda_i = ~hlda_i;
      cyc_busy_i = ($urandom_range(0, 2) == 0);
      loc_pending_i = ($urandom_range(0, 1) == 0);
      tick(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule